// File: doc/BRIEF.md
# USB Device Link State Tracker

This block follows the link condition of a full-speed USB device. It watches a filtered level that says whether bus power is present, the enable of the device's own pull-up, and a set of one-cycle event strobes that other logic derives from the line: bus reset, bus activity, bus inactivity, start-of-frame seen, J state seen while resuming, and a local request to resume. From these it moves among seven link states and decodes them into status flags for the rest of the device controller.

Timing of resets and inactivity, line filtering and packet decoding live outside; this block only orders the events it receives. Loss of power or a disabled pull-up always wins and returns the link to the detached state. A power flag qualified by the link state is also produced, so that downstream logic treats power as valid only when the link can use it.

Top module: `usb_link_tracker`

## Requirements
- R1: An active-low asynchronous reset puts the link in the detached state at once, with `detached_o` high and the other flags low.
- R2: `link_state_o` carries the state code: 0 detached, 1 powered, 2 powered-and-suspended, 3 resuming, 4 active awaiting first frame, 5 active, 6 suspended; code 7 never appears.
- R3: Whenever `vbus_ok_i` or `pullup_en_i` is low, the next state is detached, regardless of state or of any event strobe.
- R4: From detached the link goes to powered only when `vbus_ok_i` and `pullup_en_i` are both high.
- R5: In powered, a bus reset leads to active-awaiting-frame; failing that a resume request leads to resuming; failing that inactivity leads to powered-and-suspended.
- R6: In powered-and-suspended, a bus reset leads to active-awaiting-frame; failing that bus activity leads back to powered.
- R7: Resuming leads to active-awaiting-frame on either a J state or a bus reset.
- R8: In active-awaiting-frame, inactivity leads to suspended; failing that a frame start leads to active.
- R9: In active, inactivity leads to suspended; failing that a bus reset leads back to active-awaiting-frame.
- R10: In suspended, a bus reset leads to active-awaiting-frame; failing that bus activity leads to resuming.
- R11: `detached_o` is high only in state 0; `suspended_o` is high in states 2 and 6; `active_o` is high in states 4 and 5.
- R12: `vbus_qual_o` is high when `vbus_ok_i` is high and the state is 1, 4 or 5; otherwise it is low.
- R13: A strobe with no transition defined for the current state leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbus_ok_i | input | 1 | Filtered bus power present |
| pullup_en_i | input | 1 | Device pull-up enabled |
| bus_reset_i | input | 1 | One-cycle bus reset event |
| bus_active_i | input | 1 | One-cycle bus activity event |
| bus_idle_i | input | 1 | One-cycle bus inactivity event |
| frame_start_i | input | 1 | One-cycle start-of-frame event |
| j_seen_i | input | 1 | One-cycle J state during resume |
| resume_req_i | input | 1 | One-cycle local resume request |
| link_state_o | output | 3 | Current state code |
| detached_o | output | 1 | Link detached |
| suspended_o | output | 1 | Link suspended (either kind) |
| active_o | output | 1 | Link active (either kind) |
| vbus_qual_o | output | 1 | Power sense qualified by link state |

## Verification
The transitions are driven by a walk through every state in which strobes are applied alone and in competing pairs or triples, so that each per-state priority order is separated from its reverse: resume against inactivity in powered, inactivity against reset in active, reset against activity in both suspended states. Strobes that have no meaning in a state (a frame start while powered or powered-and-suspended, activity while resuming) show that unused events leave the state alone. Power and pull-up loss are applied in five different states, once together with a competing reset, to show that detachment overrides everything; an asynchronous reset taken between clock edges and a power flag checked with power present in the detached state close the corner cases.

// File: rtl/usb_link_tracker.sv
module usb_link_tracker (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vbus_ok_i,
  input  logic       pullup_en_i,
  input  logic       bus_reset_i,
  input  logic       bus_active_i,
  input  logic       bus_idle_i,
  input  logic       frame_start_i,
  input  logic       j_seen_i,
  input  logic       resume_req_i,
  output logic [2:0] link_state_o,
  output logic       detached_o,
  output logic       suspended_o,
  output logic       active_o,
  output logic       vbus_qual_o
);

  typedef enum logic [2:0] {
    StDetached  = 3'd0,
    StPowered   = 3'd1,
    StPwrSusp   = 3'd2,
    StResuming  = 3'd3,
    StAwaitSof  = 3'd4,
    StActive    = 3'd5,
    StSuspended = 3'd6
  } link_st_e;

  link_st_e st_q, st_d;
  logic     attach_ok;

  assign attach_ok = vbus_ok_i & pullup_en_i;

  always_comb begin
    st_d = st_q;
    if (!attach_ok) begin
      st_d = StDetached;
    end else begin
      unique case (st_q)
        StDetached:  st_d = StPowered;
        StPowered: begin
          if (bus_reset_i)       st_d = StAwaitSof;
          else if (resume_req_i) st_d = StResuming;
          else if (bus_idle_i)   st_d = StPwrSusp;
        end
        StPwrSusp: begin
          if (bus_reset_i)       st_d = StAwaitSof;
          else if (bus_active_i) st_d = StPowered;
        end
        StResuming: begin
          if (j_seen_i || bus_reset_i) st_d = StAwaitSof;
        end
        StAwaitSof: begin
          if (bus_idle_i)         st_d = StSuspended;
          else if (frame_start_i) st_d = StActive;
        end
        StActive: begin
          if (bus_idle_i)       st_d = StSuspended;
          else if (bus_reset_i) st_d = StAwaitSof;
        end
        StSuspended: begin
          if (bus_reset_i)       st_d = StAwaitSof;
          else if (bus_active_i) st_d = StResuming;
        end
        default: st_d = StDetached;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= StDetached;
    else         st_q <= st_d;
  end

  assign link_state_o = st_q;
  assign detached_o   = (st_q == StDetached);
  assign suspended_o  = (st_q == StPwrSusp) || (st_q == StSuspended);
  assign active_o     = (st_q == StAwaitSof) || (st_q == StActive);
  assign vbus_qual_o  = vbus_ok_i & ((st_q == StPowered) | active_o);

endmodule

// File: rtl/usb_link_tracker_chk.sv
module usb_link_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vbus_ok_i,
  input logic       pullup_en_i,
  input logic       bus_idle_i,
  input logic       frame_start_i,
  input logic       bus_reset_i,
  input logic [2:0] link_state_o,
  input logic       detached_o,
  input logic       suspended_o,
  input logic       active_o,
  input logic       vbus_qual_o
);

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_state_o != 3'd7);

  assert_drop_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vbus_ok_i || !pullup_en_i) |=> (link_state_o == 3'd0));

  assert_attach_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd0 && vbus_ok_i && pullup_en_i) |=> (link_state_o == 3'd1));

  assert_first_sof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd4 && vbus_ok_i && pullup_en_i && !bus_idle_i && frame_start_i)
    |=> (link_state_o == 3'd5));

  assert_idle_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == 3'd5 && vbus_ok_i && pullup_en_i && bus_idle_i && bus_reset_i)
    |=> (link_state_o == 3'd6));

  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({detached_o, suspended_o, active_o}) <= 1);

  assert_qual_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vbus_ok_i |-> !vbus_qual_o);

endmodule

bind usb_link_tracker usb_link_tracker_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vbus_ok_i     (vbus_ok_i),
  .pullup_en_i   (pullup_en_i),
  .bus_idle_i    (bus_idle_i),
  .frame_start_i (frame_start_i),
  .bus_reset_i   (bus_reset_i),
  .link_state_o  (link_state_o),
  .detached_o    (detached_o),
  .suspended_o   (suspended_o),
  .active_o      (active_o),
  .vbus_qual_o   (vbus_qual_o)
);

// File: tb/usb_link_tracker_test.sv
module usb_link_tracker_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vbus_ok_i = 1'b0, pullup_en_i = 1'b0;
  logic bus_reset_i = 1'b0, bus_active_i = 1'b0, bus_idle_i = 1'b0;
  logic frame_start_i = 1'b0, j_seen_i = 1'b0, resume_req_i = 1'b0;
  logic [2:0] link_state_o;
  logic detached_o, suspended_o, active_o, vbus_qual_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_link_tracker uut (
    .clk_i(clk), .rst_ni(rst_ni), .vbus_ok_i(vbus_ok_i), .pullup_en_i(pullup_en_i),
    .bus_reset_i(bus_reset_i), .bus_active_i(bus_active_i), .bus_idle_i(bus_idle_i),
    .frame_start_i(frame_start_i), .j_seen_i(j_seen_i), .resume_req_i(resume_req_i),
    .link_state_o(link_state_o), .detached_o(detached_o), .suspended_o(suspended_o),
    .active_o(active_o), .vbus_qual_o(vbus_qual_o)
  );

  // fields: vbus pullup | reset active idle sof j resume | expected state
  localparam int NV = 37;
  localparam logic [10:0] VEC [NV] = '{
    11'b10_000000_000, // R4 pull-up missing
    11'b01_000000_000, // R4 power missing
    11'b11_000000_001, // R4 attach
    11'b11_000100_001, // R13 frame start ignored in powered
    11'b11_001001_011, // R5 resume beats idle
    11'b11_010000_011, // R13 activity ignored in resuming
    11'b11_000010_100, // R7 J state
    11'b11_001100_110, // R8 idle beats frame start
    11'b11_110000_100, // R10 reset beats activity
    11'b11_000100_101, // R8 first frame
    11'b11_101000_110, // R9 idle beats reset
    11'b11_010000_011, // R10 activity -> resuming
    11'b11_100000_100, // R7 reset
    11'b11_000100_101, // R8
    11'b11_100000_100, // R9 reset -> awaiting frame
    11'b11_000100_101, // R8
    11'b10_000100_000, // R3 pull-up off from active
    11'b11_000000_001, // R4
    11'b11_101001_100, // R5 reset beats resume and idle
    11'b10_000000_000, // R3 from awaiting frame
    11'b11_000000_001, // R4
    11'b11_001000_010, // R5 idle -> powered-suspended
    11'b11_000100_010, // R13 frame start ignored
    11'b11_010000_001, // R6 activity -> powered
    11'b11_001000_010, // R5
    11'b11_110000_100, // R6 reset beats activity
    11'b01_000000_000, // R3 power off from awaiting frame
    11'b11_000000_001, // R4
    11'b11_000001_011, // R5 resume
    11'b01_000000_000, // R3 from resuming
    11'b11_000000_001, // R4
    11'b11_001000_010, // R5
    11'b01_000000_000, // R3 from powered-suspended
    11'b11_000000_001, // R4
    11'b11_100000_100, // R5 reset
    11'b11_001000_110, // R8 idle -> suspended
    11'b10_100000_000  // R3 drop beats reset in suspended
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {vbus_ok_i, pullup_en_i, bus_reset_i, bus_active_i, bus_idle_i,
     frame_start_i, j_seen_i, resume_req_i} = v;
  endtask

  task automatic chk_flags(input logic [2:0] st, input logic vb);
    chk("R2 state", {5'd0, link_state_o}, {5'd0, st});
    chk("R11 flags", {5'd0, detached_o, suspended_o, active_o},
        {5'd0, st == 3'd0, st == 3'd2 || st == 3'd6, st == 3'd4 || st == 3'd5});
    chk("R12 vbus_qual", {7'd0, vbus_qual_o},
        {7'd0, vb & (st == 3'd1 || st == 3'd4 || st == 3'd5)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with power present: R12 qualified flag still low
    drive(8'b11_000000);
    repeat (2) @(negedge clk);
    chk_flags(3'd0, 1'b1);
    drive(8'b00_000000);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10:3]);
      @(posedge clk);
      @(negedge clk);
      chk_flags(VEC[i][2:0], VEC[i][10]);
    end
    // R1 asynchronous reset between edges from active
    drive(8'b11_000000);
    @(negedge clk);
    drive(8'b11_100000);
    @(negedge clk);
    drive(8'b11_000100);
    @(negedge clk);
    chk("R1 precondition", {5'd0, link_state_o}, 8'd5);
    #2 rst_ni = 1'b0;
    #1 chk("R1 async", {5'd0, link_state_o, detached_o, active_o}, {5'd0, 3'd0, 1'b1, 1'b0});
    drive(8'b00_000000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_flags(3'd0, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule